// File: doc/BRIEF.md
# Register Front End with Provisioning Order Guard

This block sits between a microprocessor bus and the five register regions of a multi-region data interface device: core, UT, OHP, PT and DE. Each request carries a 16-bit address, a write flag and 16-bit write data. The block checks the address against the legal window of each region and raises a one-hot region select. It rejects reserved addresses and returns a response one clock later.

Setup of the device has a fixed order. The core mode register (0x0010) has to be written first, and the core channel control register (0x0011) second. After that the other core registers may be written in any order. The block tracks this order. It drops core writes that come out of turn and records them in a sticky flag. It blocks writes to the non-core regions until setup is complete. A write to either ordering register resets the non-core regions for one cycle.

The register contents of the regions are not part of this block. A stub responder returns a fixed pattern for each read.

Top module: `regfront`

## Requirements
- R1: A request whose address has any of bits 15..13 set is rejected. One cycle later access_error is 1, region_sel is 0 and rsp_rdata is 0x0000.
- R2: The legal windows are core 0x0000..0x001F, UT 0x0200..0x0226, OHP 0x0400..0x05C2, PT 0x0800..0x0AF8 and DE 0x1000..0x1607. The region is chosen by address bits 12..9. The select bits are core=bit0, UT=bit1, OHP=bit2, PT=bit3, DE=bit4. An address beyond a window's upper bound, or with an unassigned value of bits 12..9, is rejected in the same way as R1.
- R3: A read of a legal address returns rsp_rdata = {code[3:0], addr[11:0]}, with code core=1, UT=2, OHP=3, PT=4, DE=5. Every write response returns rsp_rdata = 0x0000.
- R4: Each request produces exactly one response with rsp_valid=1 on the next clock. region_sel, access_error and region_reset are 0 on cycles without a response.
- R5: While waiting for the mode register, a core write to any address other than 0x0010 is dropped (region_sel=0) and sets sequence_error. A write to 0x0010 is accepted.
- R6: While waiting for the channel register, a core write to any address other than 0x0011 is dropped and sets sequence_error. A write to 0x0011 is accepted, and prov_done rises in the same response cycle.
- R7: Once setup is complete, every legal core write is accepted (core select, no error) in any order.
- R8: Before setup is complete, a write to UT, OHP, PT or DE is blocked: region_sel=0 and access_error=1. Reads of legal addresses are accepted in every state.
- R9: region_reset is high for exactly the response cycle of an accepted write to 0x0010 or 0x0011, in any state. Dropped writes, other core writes and all reads leave it low.
- R10: After reset, all outputs are 0. sequence_error and prov_done stay high until the next reset once they have been set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Register address |
| req_wdata | input | 16 | Write data toward the regions |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_rdata | output | 16 | Read data |
| region_sel | output | 5 | One-hot region select for an accepted access |
| region_wdata | output | 16 | Write data registered alongside the select |
| region_we | output | 1 | The accepted access is a write |
| access_error | output | 1 | Rejected address or blocked write, one cycle |
| sequence_error | output | 1 | Sticky: out-of-order core write seen |
| region_reset | output | 1 | One-cycle reset toward non-core regions |
| prov_done | output | 1 | Setup order complete |

## Verification
The case hardest to reach from the ports is a device that has already recorded an ordering error and must still finish setup correctly. The stimulus first writes the channel register before the mode register, and then writes an unrelated core register between the two legal writes. It then checks that sequence_error stays set, that the later legal writes are still accepted with their reset pulses, and that writes to other regions become available only afterwards. Addresses just beyond each window's upper bound are also driven, because they share bits 12..9 with legal addresses.

// File: rtl/regfront.sv
module regfront #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int NREG = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  output logic [NREG-1:0] region_sel,
  output logic [DW-1:0]   region_wdata,
  output logic            region_we,
  output logic            access_error,
  output logic            sequence_error,
  output logic            region_reset,
  output logic            prov_done
);
  localparam logic [12:0] CORE_TOP = 13'h001F;
  localparam logic [12:0] UT_TOP   = 13'h0226;
  localparam logic [12:0] OHP_TOP  = 13'h05C2;
  localparam logic [12:0] PT_TOP   = 13'h0AF8;
  localparam logic [12:0] DE_TOP   = 13'h1607;
  localparam logic [AW-1:0] MODE_ADDR = 16'h0010;
  localparam logic [AW-1:0] CHAN_ADDR = 16'h0011;

  typedef enum logic [1:0] {WAIT_MODE, WAIT_CHANNEL, PROVISIONED} seq_t;
  seq_t state, state_n;

  logic [2:0] rid;
  logic       in_win, legal;
  logic [12:0] off;

  assign off = req_addr[12:0];

  always_comb begin
    rid = 3'd0;
    in_win = 1'b0;
    unique case (req_addr[12:9])
      4'd0:                    begin rid = 3'd0; in_win = off <= CORE_TOP; end
      4'd1:                    begin rid = 3'd1; in_win = off <= UT_TOP;   end
      4'd2:                    begin rid = 3'd2; in_win = off <= OHP_TOP;  end
      4'd4, 4'd5:              begin rid = 3'd3; in_win = off <= PT_TOP;   end
      4'd8, 4'd9, 4'd10, 4'd11: begin rid = 3'd4; in_win = off <= DE_TOP;  end
      default:                 begin rid = 3'd0; in_win = 1'b0;           end
    endcase
  end

  assign legal = (req_addr[AW-1:13] == '0) && in_win;

  logic is_core, wr, accept, blk, seq_drop, rst_hit;
  assign is_core = legal && (rid == 3'd0);
  assign wr      = req_valid && req_write;

  always_comb begin
    state_n  = state;
    seq_drop = 1'b0;
    if (wr && is_core) begin
      unique case (state)
        WAIT_MODE:    if (req_addr == MODE_ADDR) state_n = WAIT_CHANNEL; else seq_drop = 1'b1;
        WAIT_CHANNEL: if (req_addr == CHAN_ADDR) state_n = PROVISIONED;  else seq_drop = 1'b1;
        default:      state_n = PROVISIONED;
      endcase
    end
  end

  assign blk     = wr && legal && !is_core && (state != PROVISIONED);
  assign accept  = req_valid && legal && !blk && !seq_drop;
  assign rst_hit = wr && accept && ((req_addr == MODE_ADDR) || (req_addr == CHAN_ADDR));

  logic [NREG-1:0] sel_n;
  always_comb begin
    sel_n = '0;
    if (accept) sel_n[rid] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state          <= WAIT_MODE;
      rsp_valid      <= 1'b0;
      rsp_rdata      <= '0;
      region_sel     <= '0;
      region_wdata   <= '0;
      region_we      <= 1'b0;
      access_error   <= 1'b0;
      sequence_error <= 1'b0;
      region_reset   <= 1'b0;
      prov_done      <= 1'b0;
    end else begin
      state          <= state_n;
      rsp_valid      <= req_valid;
      rsp_rdata      <= (req_valid && !req_write && legal) ?
                        {{1'b0, rid} + 4'd1, req_addr[11:0]} : '0;
      region_sel     <= sel_n;
      region_wdata   <= (wr && accept) ? req_wdata : '0;
      region_we      <= wr && accept;
      access_error   <= req_valid && (!legal || blk);
      sequence_error <= sequence_error || seq_drop;
      region_reset   <= rst_hit;
      prov_done      <= (state_n == PROVISIONED);
    end
  end
endmodule

module regfront_chk #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int NREG = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_write,
  input logic [AW-1:0]   req_addr,
  input logic            rsp_valid,
  input logic [DW-1:0]   rsp_rdata,
  input logic [NREG-1:0] region_sel,
  input logic            access_error,
  input logic            sequence_error,
  input logic            region_reset,
  input logic            prov_done
);
  assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(region_sel));
  assert_err_no_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
    access_error |-> (region_sel == '0 && rsp_rdata == '0));
  assert_rsp_follows_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_quiet_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (region_sel == '0 && !access_error && !region_reset));
  assert_reset_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && (req_addr == 16'h0010 || req_addr == 16'h0011) |=> region_reset || region_sel == '0);
  assert_reset_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    region_reset |-> region_sel == 5'b00001);
  assert_seqerr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sequence_error |=> sequence_error);
  assert_prov_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    prov_done |=> prov_done);
endmodule

bind regfront regfront_chk #(.AW(AW), .DW(DW), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .region_sel(region_sel), .access_error(access_error),
  .sequence_error(sequence_error), .region_reset(region_reset),
  .prov_done(prov_done));

// File: tb/test_regfront.sv
module test_regfront;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic rsp_valid, region_we, access_error, sequence_error, region_reset, prov_done;
  logic [15:0] rsp_rdata, region_wdata;
  logic [4:0] region_sel;

  always #10 clk = ~clk;

  regfront i_regfront (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .region_sel(region_sel), .region_wdata(region_wdata),
    .region_we(region_we), .access_error(access_error),
    .sequence_error(sequence_error), .region_reset(region_reset),
    .prov_done(prov_done));

  typedef struct {
    logic [4:0]  sel;
    logic [15:0] rd;
    logic        acc, rrst, seqe, prov;
    string       tag;
  } exp_t;

  exp_t q[$];
  int compared = 0, mismatched = 0;
  int m_state = 0;
  logic m_seqe = 1'b0;
  bit done = 1'b0;

  function automatic void decode(input logic [15:0] a, output logic ok, output int r);
    logic [15:0] top;
    r = -1; top = '0;
    case (a[12:9])
      4'd0: begin r = 0; top = 16'h001F; end
      4'd1: begin r = 1; top = 16'h0226; end
      4'd2: begin r = 2; top = 16'h05C2; end
      4'd4, 4'd5: begin r = 3; top = 16'h0AF8; end
      4'd8, 4'd9, 4'd10, 4'd11: begin r = 4; top = 16'h1607; end
      default: r = -1;
    endcase
    ok = (a[15:13] == 3'b000) && (r >= 0) && (a <= top);
  endfunction

  task automatic access(input bit w, input logic [15:0] a, input string tag);
    exp_t e;
    logic ok; int r;
    decode(a, ok, r);
    e.sel = '0; e.rd = '0; e.acc = 1'b0; e.rrst = 1'b0; e.tag = tag;
    if (!ok) e.acc = 1'b1;
    else if (!w) begin
      e.sel[r] = 1'b1;
      e.rd = {4'(r + 1), a[11:0]};
    end else if (r != 0) begin
      if (m_state == 2) e.sel[r] = 1'b1; else e.acc = 1'b1;
    end else begin
      if (m_state == 0) begin
        if (a == 16'h0010) begin m_state = 1; e.sel = 5'b00001; e.rrst = 1'b1; end
        else m_seqe = 1'b1;
      end else if (m_state == 1) begin
        if (a == 16'h0011) begin m_state = 2; e.sel = 5'b00001; e.rrst = 1'b1; end
        else m_seqe = 1'b1;
      end else begin
        e.sel = 5'b00001;
        e.rrst = (a == 16'h0010) || (a == 16'h0011);
      end
    end
    e.seqe = m_seqe; e.prov = (m_state == 2);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = {a[7:0], 8'h5A};
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  always begin
    @(posedge clk); #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      compared++;
      if (!rsp_valid || region_sel !== e.sel || rsp_rdata !== e.rd || access_error !== e.acc ||
          region_reset !== e.rrst || sequence_error !== e.seqe || prov_done !== e.prov) begin
        mismatched++;
        $display("FAIL %s: got v=%b sel=%b rd=%h acc=%b rst=%b seq=%b prov=%b exp sel=%b rd=%h acc=%b rst=%b seq=%b prov=%b",
                 e.tag, rsp_valid, region_sel, rsp_rdata, access_error, region_reset,
                 sequence_error, prov_done, e.sel, e.rd, e.acc, e.rrst, e.seqe, e.prov);
      end
    end else if (rst_n) begin
      compared++;
      if (rsp_valid || region_sel != '0 || access_error || region_reset) begin
        mismatched++;
        $display("FAIL R4: idle got v=%b sel=%b acc=%b rst=%b exp all 0",
                 rsp_valid, region_sel, access_error, region_reset);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    compared++;
    if (rsp_valid || rsp_rdata != '0 || region_sel != '0 || access_error || sequence_error ||
        region_reset || prov_done || region_we) begin
      mismatched++;
      $display("FAIL R10: reset state got nonzero outputs exp all 0");
    end
    @(negedge clk); rst_n = 1'b1;
    access(0, 16'h0010, "R3 read core pre-setup R8");
    access(0, 16'h0226, "R2 UT upper bound");
    access(0, 16'h0227, "R2 UT past bound");
    access(0, 16'h2000, "R1 bit13");
    access(0, 16'hE010, "R1 high bits");
    access(1, 16'h8011, "R1 write high bit");
    access(0, 16'h0600, "R2 unassigned index");
    access(1, 16'h0200, "R8 UT write blocked");
    access(1, 16'h1000, "R8 DE write blocked");
    access(1, 16'h0011, "R5 channel first dropped");
    access(1, 16'h0005, "R5 other core dropped");
    access(1, 16'h0010, "R5 mode accepted R9");
    access(1, 16'h0400, "R8 OHP blocked mid-setup");
    access(1, 16'h0005, "R6 other core dropped");
    access(1, 16'h0010, "R6 mode again dropped");
    access(1, 16'h0011, "R6 channel accepted R9");
    access(1, 16'h001F, "R7 core top no reset R9");
    access(1, 16'h0000, "R7 core zero");
    access(1, 16'h0010, "R9 mode rewrite reset");
    access(1, 16'h0020, "R2 core past bound");
    access(1, 16'h0226, "R8 UT write ok");
    access(1, 16'h05C2, "R2 OHP top");
    access(1, 16'h05C3, "R2 OHP past");
    access(1, 16'h0AF8, "R2 PT top");
    access(1, 16'h0AF9, "R2 PT past");
    access(1, 16'h1607, "R2 DE top");
    access(1, 16'h1608, "R2 DE past");
    for (int k = 0; k < 8; k++) begin
      access(0, 16'h0000 + 16'(k * 3), "R3 core read");
      access(0, 16'h0400 + 16'(k * 37), "R3 OHP read");
      access(0, 16'h0800 + 16'(k * 101), "R3 PT read");
      access(0, 16'h1000 + 16'(k * 199), "R3 DE read");
    end
    access(0, 16'h0011, "R9 read no reset");
    repeat (4) @(negedge clk);
    compared++;
    if (!sequence_error || !prov_done) begin
      mismatched++;
      $display("FAIL R10: got seq=%b prov=%b exp 1 1", sequence_error, prov_done);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule